// File: doc/BRIEF.md
# Coherence Domain Lookup Classifier

This block sits beside one bank of a shared last-level cache and classifies every request arriving from a private second-level cache. For each request it decides whether the line lives in the hardware-coherent domain or in the software-managed domain. Three sources decide, in strict priority:
- the directory lookup result, supplied by the surrounding bank logic;
- a small set of address windows, each with a start address, a size and an enable;
- one bit per 32-byte line in a bitmap held in memory.

A directory hit is routed to the directory. If the data array also misses, the decision waits for a fill-complete pulse. A directory miss that falls inside an enabled window is answered at once as an incoherent reply. Any other miss fetches the bitmap word through a valid/ready read port with variable latency. The bit selected from that word picks the route:
- a set bit gives an incoherent reply;
- a clear bit allocates a new directory entry.

The bitmap's word address is formed from a base-address register plus an offset built from the request address. That offset lets each cache bank hold the part of the table that covers its own lines. Only one request is in flight at a time, and only one bitmap read is outstanding at a time.

Top module: `cdom_classifier`

## Requirements
- R1: After reset, `dec_valid` and `bmp_req_valid` are 0 and `req_ready` is 1.
- R2: A request accepted with `dir_hit`=1 and `arr_hit`=1 yields `dec_valid`=1 with `dec_route`=1 (directory) on the clock edge after acceptance, whether or not the address lies in a window.
- R3: A request accepted with `dir_hit`=1 and `arr_hit`=0 gives no decision until `fill_done` is sampled high. The decision `dec_route`=1 appears on the following edge.
- R4: On a directory miss, an address with start <= addr < start+size in a window whose enable bit is 1 yields `dec_route`=2 (incoherent) with `dec_incoh`=1 on the edge after acceptance. A window with enable 0 never matches.
- R5: A directory miss outside every enabled window issues one bitmap read. Its word address is `bmp_base` + ({addr[31:24], addr[13:11], addr[23:14], addr[10]} << 2).
- R6: The bitmap bit is `bmp_rsp_data[addr[9:5]]`. A value of 1 gives `dec_route`=2 with `dec_incoh`=1. A value of 0 gives `dec_route`=3 (allocate) with `dec_incoh`=0. The decision appears on the edge after `bmp_rsp_valid` is sampled.
- R7: `bmp_req_valid` and `bmp_req_addr` stay stable until `bmp_req_ready` is sampled. After that handshake `bmp_req_valid` is 0 until the next bitmap lookup.
- R8: `req_ready` is 0 from acceptance until the decision is presented. `dec_incoh` is 1 exactly when `dec_route`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Classifier idle, request accepted when valid |
| req_addr | input | 32 | Request byte address |
| dir_hit | input | 1 | Directory lookup hit for the request |
| arr_hit | input | 1 | Data array hit for the request |
| fill_done | input | 1 | Pending fill from memory has completed |
| rng_en | input | N_RANGES | Enable bit per address window |
| rng_start | input | 32*N_RANGES | Window start addresses, window k at bits 32k+31:32k |
| rng_size | input | 32*N_RANGES | Window sizes in bytes, same packing |
| bmp_base | input | 32 | Bitmap base address register |
| bmp_req_valid | output | 1 | Bitmap read request valid |
| bmp_req_ready | input | 1 | Bitmap read request accepted |
| bmp_req_addr | output | 32 | Bitmap word address |
| bmp_rsp_valid | input | 1 | Bitmap read data valid |
| bmp_rsp_data | input | 32 | Bitmap word |
| dec_valid | output | 1 | Decision pulse |
| dec_route | output | 2 | 1 directory, 2 incoherent reply, 3 allocate entry |
| dec_incoh | output | 1 | Incoherent flag for the reply |

## Verification
The hardest situation to reach from the ports is a bitmap lookup whose outcome depends only on the bit selected by addr[9:5]. A bitmap pattern that happens to give the expected route cannot tell a correct bit index from a wrong one. The bench therefore has responder modes that return a word with only the expected bit set, and a word with every bit set except that one. These tell a wrong bit index or a wrong polarity apart from a correct one. A stall in the request handshake and a delay in the response are both swept, so the single-outstanding rule and the address-stability rule are exercised under back-pressure.

// File: rtl/cdom_pkg.sv
package cdom_pkg;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int BIT_W   = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_DIR   = 2'd1,
    ROUTE_INCOH = 2'd2,
    ROUTE_ALLOC = 2'd3
  } route_e;

  // Byte offset of the bitmap word covering a line (bank-local interleave).
  function automatic logic [ADDR_W-1:0] bmp_word_offset(input logic [ADDR_W-1:0] a);
    return {8'd0, a[31:24], a[13:11], a[23:14], a[10], 2'b00};
  endfunction

  // Bit inside the bitmap word for a 32-byte line.
  function automatic logic [BIT_W-1:0] bmp_bit_index(input logic [ADDR_W-1:0] a);
    return a[9:5];
  endfunction

  // Window test that cannot overflow: start <= a < start + size.
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] start,
                                     input logic [ADDR_W-1:0] size);
    return (a >= start) && ((a - start) < size);
  endfunction
endpackage

// File: rtl/cdom_range_match.sv
module cdom_range_match
  import cdom_pkg::*;
#(
  parameter int N_RANGES = 3
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [N_RANGES-1:0]        en,
  input  logic [N_RANGES*ADDR_W-1:0] start,
  input  logic [N_RANGES*ADDR_W-1:0] size,
  output logic                       hit
);
  logic [N_RANGES-1:0] win_hit;

  for (genvar g = 0; g < N_RANGES; g++) begin : g_win
    assign win_hit[g] = en[g] &&
                        in_window(addr, start[g*ADDR_W +: ADDR_W], size[g*ADDR_W +: ADDR_W]);
  end

  assign hit = |win_hit;
endmodule

// File: rtl/cdom_bitmap_addr.sv
module cdom_bitmap_addr
  import cdom_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BIT_W-1:0]  bit_idx
);
  assign word_addr = base + bmp_word_offset(addr);
  assign bit_idx   = bmp_bit_index(addr);
endmodule

// File: rtl/cdom_ctrl.sv
module cdom_ctrl
  import cdom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              dir_hit,
  input  logic              arr_hit,
  input  logic              fill_done,
  input  logic              rng_hit,
  input  logic [ADDR_W-1:0] lk_word_addr,
  input  logic [BIT_W-1:0]  lk_bit_idx,
  output logic              bmp_req_valid,
  input  logic              bmp_req_ready,
  output logic [ADDR_W-1:0] bmp_req_addr,
  input  logic              bmp_rsp_valid,
  input  logic [WORD_W-1:0] bmp_rsp_data,
  output logic              dec_valid,
  output logic [1:0]        dec_route,
  output logic              dec_incoh
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_BREQ, S_BRSP} state_e;
  state_e state;

  logic [BIT_W-1:0] bit_q;

  // Named internal events
  logic accept, bmp_hs, waiting_fill, waiting_rsp, rsp_bit;
  assign accept       = req_valid && req_ready;
  assign bmp_hs       = bmp_req_valid && bmp_req_ready;
  assign waiting_fill = (state == S_FILL);
  assign waiting_rsp  = (state == S_BRSP);
  assign rsp_bit      = bmp_rsp_data[bit_q];

  assign req_ready     = (state == S_IDLE);
  assign bmp_req_valid = (state == S_BREQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      bit_q        <= '0;
      bmp_req_addr <= '0;
      dec_valid    <= 1'b0;
      dec_route    <= ROUTE_NONE;
      dec_incoh    <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          if (dir_hit) begin
            if (arr_hit) begin
              dec_valid <= 1'b1;
              dec_route <= ROUTE_DIR;
              dec_incoh <= 1'b0;
            end else begin
              state <= S_FILL;
            end
          end else if (rng_hit) begin
            dec_valid <= 1'b1;
            dec_route <= ROUTE_INCOH;
            dec_incoh <= 1'b1;
          end else begin
            bmp_req_addr <= lk_word_addr;
            bit_q        <= lk_bit_idx;
            state        <= S_BREQ;
          end
        end
        S_FILL: if (fill_done) begin
          dec_valid <= 1'b1;
          dec_route <= ROUTE_DIR;
          dec_incoh <= 1'b0;
          state     <= S_IDLE;
        end
        S_BREQ: if (bmp_req_ready) state <= S_BRSP;
        S_BRSP: if (bmp_rsp_valid) begin
          dec_valid <= 1'b1;
          dec_route <= rsp_bit ? ROUTE_INCOH : ROUTE_ALLOC;
          dec_incoh <= rsp_bit;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: a directory hit with data present is decided on the next edge
  a_r2_dir_hit: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dir_hit && arr_hit |=> dec_valid && dec_route == ROUTE_DIR);

  // R3: no decision while the fill is outstanding
  a_r3_hold_fill: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_fill && !fill_done |=> !dec_valid);

  // R3: fill completion releases a directory decision
  a_r3_fill_release: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_fill && fill_done |=> dec_valid && dec_route == ROUTE_DIR);

  // R4: window match on a directory miss answers incoherently
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dir_hit && rng_hit |=> dec_valid && dec_incoh);

  // R6: selected bitmap bit picks incoherent reply or allocation
  a_r6_bit_route: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_rsp && bmp_rsp_valid |=>
      dec_valid && dec_route == ($past(rsp_bit) ? ROUTE_INCOH : ROUTE_ALLOC));

  // R7: request held stable under back-pressure
  a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bmp_req_valid && !bmp_req_ready |=> bmp_req_valid && $stable(bmp_req_addr));

  // R7: one bitmap read outstanding
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    bmp_hs |=> !bmp_req_valid);

  // R8: the flag agrees with the route
  a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_incoh == (dec_route == ROUTE_INCOH));
endmodule

// File: rtl/cdom_classifier.sv
module cdom_classifier
  import cdom_pkg::*;
#(
  parameter int N_RANGES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [31:0]                req_addr,
  input  logic                       dir_hit,
  input  logic                       arr_hit,
  input  logic                       fill_done,
  input  logic [N_RANGES-1:0]        rng_en,
  input  logic [N_RANGES*32-1:0]     rng_start,
  input  logic [N_RANGES*32-1:0]     rng_size,
  input  logic [31:0]                bmp_base,
  output logic                       bmp_req_valid,
  input  logic                       bmp_req_ready,
  output logic [31:0]                bmp_req_addr,
  input  logic                       bmp_rsp_valid,
  input  logic [31:0]                bmp_rsp_data,
  output logic                       dec_valid,
  output logic [1:0]                 dec_route,
  output logic                       dec_incoh
);
  logic              rng_hit;
  logic [ADDR_W-1:0] lk_word_addr;
  logic [BIT_W-1:0]  lk_bit_idx;

  cdom_range_match #(.N_RANGES(N_RANGES)) u_win (
    .addr  (req_addr),
    .en    (rng_en),
    .start (rng_start),
    .size  (rng_size),
    .hit   (rng_hit)
  );

  cdom_bitmap_addr u_bmp_addr (
    .addr      (req_addr),
    .base      (bmp_base),
    .word_addr (lk_word_addr),
    .bit_idx   (lk_bit_idx)
  );

  cdom_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .dir_hit       (dir_hit),
    .arr_hit       (arr_hit),
    .fill_done     (fill_done),
    .rng_hit       (rng_hit),
    .lk_word_addr  (lk_word_addr),
    .lk_bit_idx    (lk_bit_idx),
    .bmp_req_valid (bmp_req_valid),
    .bmp_req_ready (bmp_req_ready),
    .bmp_req_addr  (bmp_req_addr),
    .bmp_rsp_valid (bmp_rsp_valid),
    .bmp_rsp_data  (bmp_rsp_data),
    .dec_valid     (dec_valid),
    .dec_route     (dec_route),
    .dec_incoh     (dec_incoh)
  );
endmodule

// File: tb/cdom_classifier_tb.sv
module cdom_classifier_tb;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic dir_hit = 1'b0, arr_hit = 1'b0, fill_done = 1'b0;
  logic [NR-1:0] rng_en;
  logic [NR*32-1:0] rng_start, rng_size;
  logic [31:0] bmp_base = 32'h8000_0000;
  logic bmp_req_valid, bmp_req_ready = 1'b0;
  logic [31:0] bmp_req_addr;
  logic bmp_rsp_valid = 1'b0;
  logic [31:0] bmp_rsp_data = '0;
  logic dec_valid, dec_incoh;
  logic [1:0] dec_route;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  // window 0: code, window 1: stacks, window 2: disabled
  assign rng_en    = 3'b011;
  assign rng_start = {32'h2000_0000, 32'h1000_0000, 32'h0000_1000};
  assign rng_size  = {32'h0000_4000, 32'h0010_0000, 32'h0000_1000};

  cdom_classifier #(.N_RANGES(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .dir_hit(dir_hit), .arr_hit(arr_hit), .fill_done(fill_done),
    .rng_en(rng_en), .rng_start(rng_start), .rng_size(rng_size), .bmp_base(bmp_base),
    .bmp_req_valid(bmp_req_valid), .bmp_req_ready(bmp_req_ready), .bmp_req_addr(bmp_req_addr),
    .bmp_rsp_valid(bmp_rsp_valid), .bmp_rsp_data(bmp_rsp_data),
    .dec_valid(dec_valid), .dec_route(dec_route), .dec_incoh(dec_incoh));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected bitmap word address, built by shifting fields into place
  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [31:0] off;
    off = (((a >> 24) & 32'hFF) << 16) | (((a >> 11) & 32'h7) << 13) |
          (((a >> 14) & 32'h3FF) << 3) | (((a >> 10) & 32'h1) << 2);
    return bmp_base + off;
  endfunction

  function automatic logic [31:0] pattern(input logic [31:0] w);
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  typedef struct packed {
    logic [31:0] addr;
    logic        dh;
    logic        ah;
    logic [7:0]  fd;   // fill delay
    logic [7:0]  ra;   // request-ready delay
    logic [7:0]  rd;   // response delay
    logic [1:0]  exp;  // 0 = decided by bitmap
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1040, 1'b1, 1'b1, 8'd0, 8'd1, 8'd1, 2'd1}, // R2 directory beats window
    '{32'h0000_1040, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd2}, // R4 code window
    '{32'h0000_1FFF, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd2}, // R4 last byte inside
    '{32'h0000_2000, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd0}, // R5 first byte past end
    '{32'h1008_0000, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd2}, // R4 stack window
    '{32'h2000_0100, 1'b0, 1'b0, 8'd0, 8'd2, 8'd3, 2'd0}, // R4 disabled window ignored
    '{32'h4567_89A0, 1'b1, 1'b0, 8'd3, 8'd1, 8'd1, 2'd1}, // R3 fill wait
    '{32'h0000_1000, 1'b1, 1'b0, 8'd1, 8'd1, 8'd1, 2'd1}, // R3 short fill
    '{32'hFFFF_FFE0, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd0}, // R5 top of memory
    '{32'h1234_5678, 1'b0, 1'b0, 8'd0, 8'd4, 8'd2, 2'd0}, // R7 back-pressure
    '{32'h0000_0FFF, 1'b0, 1'b0, 8'd0, 8'd1, 8'd5, 2'd0}  // R6 just below window
  };

  // mode 0: pattern, 1: only expected bit set, 2: all but expected bit
  task automatic run_vec(input vec_t v, input int mode, input string tag);
    logic [31:0] wexp, data;
    logic [4:0] bidx;
    logic [1:0] rexp;
    int lat_exp, n, hs_n;
    bit done;
    wexp = exp_word(v.addr);
    bidx = v.addr[9:5];
    case (mode)
      1: data = 32'd1 << bidx;
      2: data = ~(32'd1 << bidx);
      default: data = pattern(wexp);
    endcase
    if (v.dh) begin
      rexp = 2'd1;
      lat_exp = v.ah ? 1 : int'(v.fd) + 1;
    end else if (v.exp != 2'd0) begin
      rexp = v.exp;
      lat_exp = 1;
    end else begin
      rexp = data[bidx] ? 2'd2 : 2'd3;
      lat_exp = int'(v.ra) + int'(v.rd) + 1;
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R8", {tag, " idle before request"}, req_ready, 1);
    req_valid = 1'b1; req_addr = v.addr; dir_hit = v.dh; arr_hit = v.ah;
    n = 0; hs_n = 0; done = 0;
    while (!done && n < 60) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      req_valid = 1'b0;
      fill_done = 1'b0; bmp_req_ready = 1'b0; bmp_rsp_valid = 1'b0;
      if (dec_valid) begin
        done = 1;
      end else begin
        if (n == 1)
          check(req_ready == 1'b0, "R8", {tag, " busy after accept"}, req_ready, 0);
        if (v.dh && !v.ah && n == int'(v.fd)) fill_done = 1'b1;
        if (hs_n != 0 && n == hs_n + 1)
          check(bmp_req_valid == 1'b0, "R7", {tag, " single outstanding"}, bmp_req_valid, 0);
        if (bmp_req_valid && hs_n == 0 && n >= int'(v.ra)) begin
          check(bmp_req_addr == wexp, "R5", {tag, " bitmap word address"}, bmp_req_addr, wexp);
          bmp_req_ready = 1'b1;
          hs_n = n;
        end
        if (hs_n != 0 && n == hs_n + int'(v.rd)) begin
          bmp_rsp_valid = 1'b1;
          bmp_rsp_data = data;
        end
      end
    end
    check(done, tag, "decision arrived", done, 1);
    check(dec_route == rexp, tag, "route", dec_route, rexp);
    check(dec_incoh == (rexp == 2'd2), "R8", {tag, " incoherent flag"}, dec_incoh, rexp == 2'd2);
    check(n == lat_exp, tag, "decision cycle", n, lat_exp);
    if (!v.dh && v.exp == 2'd0)
      check(hs_n != 0, "R5", {tag, " bitmap read issued"}, hs_n != 0, 1);
    else
      check(hs_n == 0, "R5", {tag, " no bitmap read"}, hs_n, 0);
  endtask

  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dec_valid == 1'b0, "R1", "dec_valid in reset", dec_valid, 0);
    check(bmp_req_valid == 1'b0, "R1", "bmp_req_valid in reset", bmp_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(dec_valid == 1'b0, "R1", "no decision after reset", dec_valid, 0);

    for (int i = 0; i < NV; i++) begin
      string t;
      if (VECS[i].dh) t = VECS[i].ah ? "R2" : "R3";
      else if (VECS[i].exp != 2'd0) t = "R4";
      else t = "R6";
      run_vec(VECS[i], 0, t);
    end

    // R6 bit selection and polarity at addr[9:5] = 13
    run_vec('{32'h3000_01A0, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd0}, 1, "R6");
    run_vec('{32'h3000_01A0, 1'b0, 1'b0, 8'd0, 8'd2, 8'd1, 2'd0}, 2, "R6");
    // R6 bit 31 and bit 0
    run_vec('{32'h5000_07E0, 1'b0, 1'b0, 8'd0, 8'd1, 8'd2, 2'd0}, 1, "R6");
    run_vec('{32'h5000_0400, 1'b0, 1'b0, 8'd0, 8'd1, 8'd1, 2'd0}, 2, "R6");
    // R7 long back-pressure with a long response
    run_vec('{32'h6ABC_DE40, 1'b0, 1'b0, 8'd0, 8'd9, 8'd7, 2'd0}, 0, "R7");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule